// File: doc/BRIEF.md
# Floating-Point Compare Condition Unit

This unit compares two IEEE-754 operands of matching precision, either single or double. It reduces the comparison to one condition bit and stores that bit in a small bank of condition codes. A 4-bit mask chooses which relations make the condition true: less, equal and unordered. The top mask bit makes a comparison involving any NaN raise invalid-operation, even when the NaN is quiet. An absolute-value option compares the magnitudes and ignores the signs. Both operands arrive as 64-bit words, and a single-precision value sits in bits 31:0.

The unit is sequenced by a three-state machine. **ST_IDLE** accepts a request when `req_valid` is high. A request with a legal format takes the transition *accept* to **ST_REPORT**. A request with an illegal format takes the transition *reject* to **ST_FAULT**. During **ST_REPORT** the unit presents the invalid-operation status to the control/status logic. It then takes the transition *commit* back to **ST_IDLE**, and on that same clock edge the selected condition-code bit is written. **ST_FAULT** raises `fault` for one cycle and then takes the transition *drop* back to **ST_IDLE** without touching the condition codes. Because of this ordering, a status report is always seen one cycle before the condition code it belongs to changes.

Top module: `fcmp_cond_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, all condition-code bits are 0, `stat_valid` and `fault` are 0, and `req_ready` is 1.
- R2: If either operand is a NaN, the relation is unordered, and less and equal are both false.
- R3: `stat_invalid` is 1 when either operand is a signalling NaN, or when a NaN is present and mask bit 3 is set. A signalling NaN has an all-ones exponent, a non-zero fraction and a clear fraction MSB.
- R4: For ordered operands, equal and less follow numeric order. +0 and -0 are equal, the infinities order as the extreme values, subnormals order by value, and less is never true together with equal.
- R5: The condition bit is (mask[2] & less) | (mask[1] & equal) | (mask[0] & unordered).
- R6: When `req_abs` is 1, both operands are compared by magnitude, so their sign bits have no effect.
- R7: `req_fmt` 0 selects single precision and uses only bits 31:0 of each operand; bits 63:32 are ignored. `req_fmt` 1 selects double precision.
- R8: `req_fmt` 2 or 3 gives a one-cycle `fault` pulse in the cycle after acceptance. It gives no `stat_valid` pulse and leaves every condition-code bit unchanged.
- R9: After an accepted legal request, `stat_valid` is 1 and `req_ready` is 0 for exactly the next cycle, while the condition codes still hold their old value. The selected bit changes only at the clock edge that ends that cycle.
- R10: A compare writes only the condition-code bit chosen by `req_cc_sel`; all other bits keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is 1 |
| req_fmt | input | 2 | Operand format: 0 single, 1 double, others illegal |
| req_a | input | 64 | First operand word |
| req_b | input | 64 | Second operand word |
| req_mask | input | 4 | Condition mask: bit2 less, bit1 equal, bit0 unordered, bit3 NaN signals |
| req_abs | input | 1 | Compare magnitudes only |
| req_cc_sel | input | 3 | Index of the condition-code bit to write |
| req_ready | output | 1 | Unit is idle and can take a request |
| stat_valid | output | 1 | Status update strobe toward the control/status register |
| stat_invalid | output | 1 | Invalid-operation flag, valid with `stat_valid` |
| fault | output | 1 | Illegal format was requested |
| cc_bits | output | 8 | Condition-code bank |

## Verification
The bench builds the unit with the default bank of eight condition codes and cycles the write index through all eight, so it exercises every bit position and the preservation of the other bits. For each precision it uses eleven operands: both infinities, both signed zeros, a minimum subnormal, ±1, −2, 1.5, a quiet NaN and a negative signalling NaN. Every ordered pair is run under all sixteen masks with and without the magnitude option, which covers every combination of less, equal and unordered that a mask can select. The single-precision operands carry different junk in their upper halves, and two illegal format codes are issued over a non-zero bank.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
    localparam int SP_EXP  = 8;
    localparam int SP_FRAC = 23;
    localparam int DP_EXP  = 11;
    localparam int DP_FRAC = 52;
    localparam int SP_W    = 1 + SP_EXP + SP_FRAC;
    localparam int DP_W    = 1 + DP_EXP + DP_FRAC;
    localparam int WORD_W  = DP_W;
    localparam int MAG_W   = DP_W - 1;

    localparam logic [1:0] FMT_SP = 2'd0;
    localparam logic [1:0] FMT_DP = 2'd1;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_REPORT = 2'd1,
        ST_FAULT  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/fcmp_operand.sv
module fcmp_operand
    import fcmp_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    input  logic              dbl_i,
    output logic              sign_o,
    output logic [MAG_W-1:0]  mag_o,
    output logic              nan_o,
    output logic              snan_o
);
    logic [SP_EXP-1:0]  sp_exp;
    logic [SP_FRAC-1:0] sp_frac;
    logic [DP_EXP-1:0]  dp_exp;
    logic [DP_FRAC-1:0] dp_frac;
    logic               sp_nan, dp_nan;

    always_comb begin
        sp_exp  = word_i[SP_W-2 -: SP_EXP];
        sp_frac = word_i[SP_FRAC-1:0];
        dp_exp  = word_i[DP_W-2 -: DP_EXP];
        dp_frac = word_i[DP_FRAC-1:0];
        sp_nan  = (&sp_exp) && (|sp_frac);
        dp_nan  = (&dp_exp) && (|dp_frac);
        if (dbl_i) begin
            sign_o = word_i[DP_W-1];
            mag_o  = word_i[DP_W-2:0];
            nan_o  = dp_nan;
            snan_o = dp_nan && !dp_frac[DP_FRAC-1];
        end else begin
            sign_o = word_i[SP_W-1];
            mag_o  = MAG_W'(word_i[SP_W-2:0]);
            nan_o  = sp_nan;
            snan_o = sp_nan && !sp_frac[SP_FRAC-1];
        end
    end
endmodule

// File: rtl/fcmp_relation.sv
module fcmp_relation
    import fcmp_pkg::*;
(
    input  logic             sign_a_i,
    input  logic [MAG_W-1:0] mag_a_i,
    input  logic             nan_a_i,
    input  logic             snan_a_i,
    input  logic             sign_b_i,
    input  logic [MAG_W-1:0] mag_b_i,
    input  logic             nan_b_i,
    input  logic             snan_b_i,
    input  logic             abs_i,
    input  logic             nan_signals_i,
    output logic             lt_o,
    output logic             eq_o,
    output logic             unord_o,
    output logic             invalid_o
);
    logic sa, sb, both_zero, eq_raw, lt_raw;

    always_comb begin
        sa        = sign_a_i && !abs_i;
        sb        = sign_b_i && !abs_i;
        both_zero = (mag_a_i == '0) && (mag_b_i == '0);
        eq_raw    = both_zero || ((mag_a_i == mag_b_i) && (sa == sb));
        if (sa != sb)
            lt_raw = sa;
        else if (sa)
            lt_raw = mag_a_i > mag_b_i;
        else
            lt_raw = mag_a_i < mag_b_i;
        unord_o   = nan_a_i || nan_b_i;
        eq_o      = !unord_o && eq_raw;
        lt_o      = !unord_o && !eq_raw && lt_raw;
        invalid_o = snan_a_i || snan_b_i || (unord_o && nan_signals_i);
    end

    always_comb begin
        if (unord_o) AST_NAN_NO_ORDER: assert (!lt_o && !eq_o); // R2
        AST_LT_EQ_EXCLUSIVE: assert (!(lt_o && eq_o)); // R4
        if (snan_a_i || snan_b_i) AST_SNAN_RAISES: assert (invalid_o); // R3
    end
endmodule

// File: rtl/fcmp_cc_bank.sv
module fcmp_cc_bank #(
    parameter int CC_COUNT = 8,
    localparam int SEL_W = (CC_COUNT > 1) ? $clog2(CC_COUNT) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we_i,
    input  logic [SEL_W-1:0]    sel_i,
    input  logic                val_i,
    output logic [CC_COUNT-1:0] cc_o
);
    logic [CC_COUNT-1:0] cc_q;

    for (genvar k = 0; k < CC_COUNT; k++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cc_q[k] <= 1'b0;
            else if (we_i && (sel_i == SEL_W'(k)))
                cc_q[k] <= val_i;
        end
    end

    assign cc_o = cc_q;

    AST_ONE_BIT_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cc_q ^ $past(cc_q)) <= 1); // R10
    AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(cc_q)); // R10
endmodule

// File: rtl/fcmp_cond_unit.sv
module fcmp_cond_unit
    import fcmp_pkg::*;
#(
    parameter int CC_COUNT = 8,
    localparam int SEL_W = (CC_COUNT > 1) ? $clog2(CC_COUNT) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [1:0]          req_fmt,
    input  logic [WORD_W-1:0]   req_a,
    input  logic [WORD_W-1:0]   req_b,
    input  logic [3:0]          req_mask,
    input  logic                req_abs,
    input  logic [SEL_W-1:0]    req_cc_sel,
    output logic                req_ready,
    output logic                stat_valid,
    output logic                stat_invalid,
    output logic                fault,
    output logic [CC_COUNT-1:0] cc_bits
);
    seq_state_t state_q, state_d;

    logic [1:0][WORD_W-1:0] op_word;
    logic [1:0]             op_sign, op_nan, op_snan;
    logic [1:0][MAG_W-1:0]  op_mag;
    logic                   is_dbl, fmt_ok;
    logic                   rel_lt, rel_eq, rel_unord, rel_inv, cond_now;
    logic                   res_q, inv_q;
    logic [SEL_W-1:0]       sel_q;
    logic                   take;

    assign op_word = {req_b, req_a};
    assign is_dbl  = (req_fmt == FMT_DP);
    assign fmt_ok  = (req_fmt == FMT_SP) || (req_fmt == FMT_DP);

    for (genvar k = 0; k < 2; k++) begin : g_opnd
        fcmp_operand u_dec (
            .word_i (op_word[k]),
            .dbl_i  (is_dbl),
            .sign_o (op_sign[k]),
            .mag_o  (op_mag[k]),
            .nan_o  (op_nan[k]),
            .snan_o (op_snan[k])
        );
    end

    fcmp_relation u_rel (
        .sign_a_i      (op_sign[0]),
        .mag_a_i       (op_mag[0]),
        .nan_a_i       (op_nan[0]),
        .snan_a_i      (op_snan[0]),
        .sign_b_i      (op_sign[1]),
        .mag_b_i       (op_mag[1]),
        .nan_b_i       (op_nan[1]),
        .snan_b_i      (op_snan[1]),
        .abs_i         (req_abs),
        .nan_signals_i (req_mask[3]),
        .lt_o          (rel_lt),
        .eq_o          (rel_eq),
        .unord_o       (rel_unord),
        .invalid_o     (rel_inv)
    );

    assign cond_now = (req_mask[2] && rel_lt) || (req_mask[1] && rel_eq)
                   || (req_mask[0] && rel_unord);
    assign take     = (state_q == ST_IDLE) && req_valid;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = fmt_ok ? ST_REPORT : ST_FAULT;
            ST_REPORT: state_d = ST_IDLE;
            ST_FAULT:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= 1'b0;
            inv_q <= 1'b0;
            sel_q <= '0;
        end else if (take && fmt_ok) begin
            res_q <= cond_now;
            inv_q <= rel_inv;
            sel_q <= req_cc_sel;
        end
    end

    always_comb begin
        req_ready    = 1'b0;
        stat_valid   = 1'b0;
        stat_invalid = 1'b0;
        fault        = 1'b0;
        unique case (state_q)
            ST_IDLE:   req_ready = 1'b1;
            ST_REPORT: begin
                stat_valid   = 1'b1;
                stat_invalid = inv_q;
            end
            ST_FAULT:  fault = 1'b1;
            default:   req_ready = 1'b0;
        endcase
    end

    fcmp_cc_bank #(.CC_COUNT(CC_COUNT)) u_cc (
        .clk   (clk),
        .rst_n (rst_n),
        .we_i  (state_q == ST_REPORT),
        .sel_i (sel_q),
        .val_i (res_q),
        .cc_o  (cc_bits)
    );

    AST_CC_AFTER_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_bits != $past(cc_bits)) |-> $past(stat_valid)); // R9
    AST_FAULT_KEEPS_CC: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (cc_bits == $past(cc_bits))); // R8
    AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stat_valid, fault, req_ready}) && (stat_valid || fault || req_ready)); // R9
    AST_REPORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |=> !stat_valid); // R9
endmodule

// File: tb/fcmp_cond_unit_test.sv
`timescale 1ns/1ps
module fcmp_cond_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_fmt = 2'd0;
    logic [63:0] req_a = '0, req_b = '0;
    logic [3:0]  req_mask = '0;
    logic        req_abs = 1'b0;
    logic [2:0]  req_cc_sel = '0;
    logic        req_ready, stat_valid, stat_invalid, fault;
    logic [7:0]  cc_bits;

    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 1'b0;
    logic [7:0] cc_model = '0;

    always #2 clk = ~clk;

    fcmp_cond_unit uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_fmt(req_fmt),
        .req_a(req_a), .req_b(req_b), .req_mask(req_mask), .req_abs(req_abs),
        .req_cc_sel(req_cc_sel), .req_ready(req_ready), .stat_valid(stat_valid),
        .stat_invalid(stat_invalid), .fault(fault), .cc_bits(cc_bits)
    );

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] sp_val(int i);
        case (i)
            0: return 32'hFF800000;  1: return 32'hC0000000;
            2: return 32'hBF800000;  3: return 32'h80000000;
            4: return 32'h00000000;  5: return 32'h00000001;
            6: return 32'h3F800000;  7: return 32'h3FC00000;
            8: return 32'h7F800000;  9: return 32'h7FC00000;
            default: return 32'hFFA00000;
        endcase
    endfunction

    function automatic logic [63:0] dp_val(int i);
        case (i)
            0: return 64'hFFF0000000000000;  1: return 64'hC000000000000000;
            2: return 64'hBFF0000000000000;  3: return 64'h8000000000000000;
            4: return 64'h0000000000000000;  5: return 64'h0000000000000001;
            6: return 64'h3FF0000000000000;  7: return 64'h3FF8000000000000;
            8: return 64'h7FF0000000000000;  9: return 64'h7FF8000000000000;
            default: return 64'hFFF4000000000000;
        endcase
    endfunction

    // class: 0 number, 1 quiet NaN, 2 signalling NaN
    function automatic int cls(int i);
        return (i == 9) ? 1 : (i == 10) ? 2 : 0;
    endfunction
    // value order: -inf -2 -1 -0 +0 denorm 1 1.5 +inf
    function automatic int vrank(int i);
        case (i)
            0: return 0; 1: return 1; 2: return 2; 3: return 3; 4: return 3;
            5: return 4; 6: return 5; 7: return 6; default: return 7;
        endcase
    endfunction
    // magnitude order: 0 denorm 1 1.5 2 inf
    function automatic int mrank(int i);
        case (i)
            0: return 5; 1: return 4; 2: return 2; 3: return 0; 4: return 0;
            5: return 1; 6: return 2; 7: return 3; default: return 5;
        endcase
    endfunction

    task automatic run_cmp(input logic [1:0] fmt, input int i, input int j,
                           input logic [3:0] mask, input logic ab, input logic [2:0] sel);
        bit unord, eq, lt, inv, res;
        string tg;
        unord = (cls(i) != 0) || (cls(j) != 0);
        if (ab) begin
            eq = !unord && (mrank(i) == mrank(j));
            lt = !unord && (mrank(i) <  mrank(j));
        end else begin
            eq = !unord && (vrank(i) == vrank(j));
            lt = !unord && (vrank(i) <  vrank(j));
        end
        inv = (cls(i) == 2) || (cls(j) == 2) || (unord && mask[3]);
        res = (mask[2] && lt) || (mask[1] && eq) || (mask[0] && unord);
        tg  = unord ? "R2" : (ab ? "R6" : "R4");
        if (fmt == 2'd0) tg = {tg, "/R7"};
        @(negedge clk);
        req_valid = 1'b1; req_fmt = fmt; req_mask = mask; req_abs = ab; req_cc_sel = sel;
        if (fmt == 2'd0) begin
            req_a = {32'hA5A5A5A5, sp_val(i)};
            req_b = {32'h5A5A5A5A, sp_val(j)};
        end else begin
            req_a = dp_val(i);
            req_b = dp_val(j);
        end
        @(negedge clk);
        req_valid = 1'b0;
        check("R9", "stat_valid", 64'(stat_valid), 64'd1);
        check("R9", "req_ready busy", 64'(req_ready), 64'd0);
        check("R9", "cc before commit", 64'(cc_bits), 64'(cc_model));
        check("R3", "stat_invalid", 64'(stat_invalid), 64'(inv));
        check("R8", "no fault", 64'(fault), 64'd0);
        @(negedge clk);
        check({tg, "/R5"}, "selected cc bit", 64'(cc_bits[sel]), 64'(res));
        cc_model[sel] = res;
        check("R10", "whole cc bank", 64'(cc_bits), 64'(cc_model));
        check("R9", "idle again", 64'({stat_valid, req_ready}), 64'b01);
    endtask

    task automatic run_fault(input logic [1:0] fmt);
        @(negedge clk);
        req_valid = 1'b1; req_fmt = fmt; req_mask = 4'hF; req_abs = 1'b0;
        req_a = '0; req_b = '0; req_cc_sel = 3'd0;
        for (int k = 0; k < 8; k++) if (!cc_model[k]) req_cc_sel = 3'(k);
        @(negedge clk);
        req_valid = 1'b0;
        check("R8", "fault pulse", 64'(fault), 64'd1);
        check("R8", "no stat_valid", 64'(stat_valid), 64'd0);
        @(negedge clk);
        check("R8", "fault one cycle", 64'(fault), 64'd0);
        check("R8", "cc unchanged", 64'(cc_bits), 64'(cc_model));
    endtask

    initial begin
        int n = 0;
        repeat (3) @(negedge clk);
        check("R1", "cc in reset", 64'(cc_bits), 64'd0);
        check("R1", "outputs in reset", 64'({req_ready, stat_valid, fault}), 64'b100);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "cc after reset", 64'(cc_bits), 64'd0);
        check("R1", "ready after reset", 64'({req_ready, stat_valid, fault}), 64'b100);
        for (int f = 0; f < 2; f++)
            for (int i = 0; i < 11; i++)
                for (int j = 0; j < 11; j++)
                    for (int m = 0; m < 16; m++)
                        for (int a = 0; a < 2; a++) begin
                            run_cmp(2'(f), i, j, 4'(m), 1'(a), 3'(n % 8));
                            n++;
                        end
        run_fault(2'd2);
        run_fault(2'd3);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule